// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Vectoring

This block combines two eight-line interrupt cores into one sixteen-line interrupt source for a processor. Lines 0 to 7 enter the primary core. Lines 8 to 15 enter the secondary core. When the secondary core picks a request, it raises request 2 of the primary core, so every secondary line is ranked at primary position 2. The processor sees a single interrupt output. It answers with a one-cycle acknowledge strobe and receives an 8-bit vector on the following cycle.

Each core keeps three things: a latched request set built from the rising edges of its lines, an in-service set, and a pending flag with the selected line. Priority is fixed: the lowest line number wins, and a core only signals lines numbered below its lowest in-service line. A single acknowledge updates the primary core. When the primary's selected line is the cascade line, the same acknowledge also updates the secondary core and produces the vector from the secondary base. A non-specific end-of-service strobe for each core releases its lowest in-service line. The two vector bases are inputs; a typical setting is 0x08 for the primary and 0x70 for the secondary.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, int_o, vld_o and vec_o are all 0.
- R2: A rising edge on an unmasked line is latched. If nothing blocks it, int_o goes high at the second rising clock edge after the edge that first samples a primary line (0–7) high, and at the third for a secondary line (8–15).
- R3: An ack_i sampled while int_o is high lowers int_o. In the next cycle only, vld_o is 1 and vec_o holds the primary base with bits [2:0] cleared, OR the selected primary line number.
- R4: When the primary's selected line is 2, the acknowledge returns the secondary base with bits [2:0] cleared, OR (line − 8).
- R5: Fixed priority: within a core the lowest pending line number is signalled first, and all secondary lines rank between primary lines 1 and 3.
- R6: While a request is signalled and not yet acknowledged, int_o stays high and the vector returned is the one selected first, even if a higher-priority line arrives later.
- R7: An acknowledged line enters in-service. Only lines numbered below a core's lowest in-service line are then signalled. An end-of-service strobe clears that core's lowest in-service line.
- R8: A masked line is not signalled, but its request stays latched and is signalled once unmasked. A line that falls while masked loses its latched request. A line that falls while unmasked keeps it.
- R9: An ack_i sampled while int_o is low has no effect: vld_o stays 0 and int_o stays low.
- R10: After an acknowledge, a waiting primary request that is eligible raises int_o at the next clock edge after the acknowledge edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Request lines; 0–7 primary, 8–15 secondary |
| mask_i | input | 16 | Per-line mask, 1 = masked |
| ack_i | input | 1 | One-cycle interrupt acknowledge |
| eoi_pri_i | input | 1 | Release lowest in-service line of the primary core |
| eoi_sec_i | input | 1 | Release lowest in-service line of the secondary core |
| pri_base_i | input | 8 | Primary vector base (bits [2:0] ignored) |
| sec_base_i | input | 8 | Secondary vector base (bits [2:0] ignored) |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector, valid with vld_o |
| vld_o | output | 1 | Vector valid for one cycle after an accepted acknowledge |

## Verification
The assertions assume that ack_i is a single-cycle strobe. They also assume the processor never acknowledges in the cycle in which vld_o is high, and that no line is high as reset is released. The stimulus meets these conditions: every acknowledge lasts one cycle and is issued at a falling clock edge, never two in a row. Every line is lowered again before it is reused, so each new request comes from a clean rising edge.

// File: rtl/cascade_irq_pkg.sv
package cascade_irq_pkg;
  localparam int unsigned CORE_PRI  = 0;
  localparam int unsigned CORE_SEC  = 1;
  localparam int unsigned NUM_CORES = 2;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N  = 8,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [SW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = SW'(i);
    end
    any_o = |vec_i;
  end
endmodule

// File: rtl/irq_core.sv
module irq_core #(
  parameter int unsigned N  = 8,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  inj_i,
  input  logic          ack_i,
  input  logic          eoi_i,
  output logic          pend_o,
  output logic [SW-1:0] sel_o,
  output logic          pick_o
);
  logic [N-1:0]  req_q, irr_q, isr_q, allow, cand, irr_clr, rise, fall;
  logic          cand_any, isr_any;
  logic [SW-1:0] cand_idx, isr_low;

  assign rise = req_i & ~req_q;
  assign fall = ~req_i & req_q;

  // a line is eligible only if no in-service bit sits at or below it
  always_comb begin
    logic run;
    run = 1'b0;
    for (int i = 0; i < N; i++) begin
      run      = run | isr_q[i];
      allow[i] = ~run;
    end
  end

  assign cand = irr_q & ~mask_i & allow;

  irq_prio_pick #(.N(N)) u_pick (.vec_i(cand),  .any_o(cand_any), .idx_o(cand_idx));
  irq_prio_pick #(.N(N)) u_low  (.vec_i(isr_q), .any_o(isr_any),  .idx_o(isr_low));

  assign pick_o = ~pend_o & cand_any & ~ack_i;

  always_comb begin
    irr_clr = fall & mask_i;
    if (pick_o) irr_clr = irr_clr | (N'(1) << cand_idx);
    if (ack_i)  irr_clr = irr_clr | (N'(1) << sel_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
      pend_o <= 1'b0;
      sel_o  <= '0;
    end else begin
      req_q <= req_i;
      irr_q <= (irr_q & ~irr_clr) | rise | inj_i;
      if (ack_i) begin
        isr_q  <= ((eoi_i && isr_any) ? (isr_q & ~(N'(1) << isr_low)) : isr_q) | (N'(1) << sel_o);
        pend_o <= 1'b0;
      end else begin
        if (eoi_i && isr_any) isr_q <= isr_q & ~(N'(1) << isr_low);
        if (pick_o) begin
          pend_o <= 1'b1;
          sel_o  <= cand_idx;
        end
      end
    end
  end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cascade_irq_pkg::*;
#(
  parameter int unsigned LINES = 8,
  parameter int unsigned VW    = 8,
  parameter int unsigned CAS   = 2,
  localparam int unsigned SW   = $clog2(LINES),
  localparam int unsigned TOT  = NUM_CORES * LINES
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [TOT-1:0] irq_i,
  input  logic [TOT-1:0] mask_i,
  input  logic           ack_i,
  input  logic           eoi_pri_i,
  input  logic           eoi_sec_i,
  input  logic [VW-1:0]  pri_base_i,
  input  logic [VW-1:0]  sec_base_i,
  output logic           int_o,
  output logic [VW-1:0]  vec_o,
  output logic           vld_o
);
  logic [LINES-1:0] inj_arr  [NUM_CORES];
  logic             ack_arr  [NUM_CORES];
  logic             eoi_arr  [NUM_CORES];
  logic             pend_arr [NUM_CORES];
  logic [SW-1:0]    sel_arr  [NUM_CORES];
  logic             pick_arr [NUM_CORES];
  logic             pri_ack, sec_ack, sec_pend, via_cas;
  logic [VW-1:0]    vec_d;

  assign via_cas = (sel_arr[CORE_PRI] == SW'(CAS));
  assign pri_ack = ack_i & pend_arr[CORE_PRI];
  assign sec_ack = pri_ack & via_cas;
  assign sec_pend = pend_arr[CORE_SEC];

  always_comb begin
    inj_arr[CORE_PRI]      = '0;
    inj_arr[CORE_PRI][CAS] = pick_arr[CORE_SEC];
    inj_arr[CORE_SEC]      = '0;
    ack_arr[CORE_PRI]      = pri_ack;
    ack_arr[CORE_SEC]      = sec_ack;
    eoi_arr[CORE_PRI]      = eoi_pri_i;
    eoi_arr[CORE_SEC]      = eoi_sec_i;
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    irq_core #(.N(LINES)) u_core (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (irq_i[g*LINES +: LINES]),
      .mask_i (mask_i[g*LINES +: LINES]),
      .inj_i  (inj_arr[g]),
      .ack_i  (ack_arr[g]),
      .eoi_i  (eoi_arr[g]),
      .pend_o (pend_arr[g]),
      .sel_o  (sel_arr[g]),
      .pick_o (pick_arr[g])
    );
  end

  // low SW bits of a base are replaced by the line number
  assign vec_d = via_cas
    ? ((sec_base_i & ~VW'(LINES - 1)) | VW'(sel_arr[CORE_SEC]))
    : ((pri_base_i & ~VW'(LINES - 1)) | VW'(sel_arr[CORE_PRI]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= pri_ack;
      if (pri_ack) vec_o <= vec_d;
    end
  end

  assign int_o = pend_arr[CORE_PRI];
endmodule

// File: rtl/cascade_irq_ctrl_chk.sv
module cascade_irq_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ack_i,
  input logic int_o,
  input logic vld_o,
  input logic sec_pend,
  input logic sec_ack
);
  AST_ACK_GIVES_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni) (ack_i && int_o) |=> vld_o); // R3
  AST_VEC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni) vld_o |=> !vld_o); // R3
  AST_INT_LOW_AT_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni) vld_o |-> !int_o); // R3
  AST_NO_STRAY_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni) !(ack_i && int_o) |=> !vld_o); // R9
  AST_INT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni) (int_o && !ack_i) |=> int_o); // R6
  AST_SEC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni) (sec_pend && !sec_ack) |=> sec_pend); // R6
endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ack_i    (ack_i),
  .int_o    (int_o),
  .vld_o    (vld_o),
  .sec_pend (sec_pend),
  .sec_ack  (sec_ack)
);

// File: tb/cascade_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq = '0, mask = '0;
  logic        ack = 1'b0, eoi_p = 1'b0, eoi_s = 1'b0;
  logic [7:0]  pri_base = 8'h08, sec_base = 8'h70;
  logic        int_o, vld_o;
  logic [7:0]  vec_o;

  int n_run = 0, n_fail = 0, cycles = 0;
  bit done = 1'b0;
  int exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  cascade_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .mask_i(mask), .ack_i(ack),
    .eoi_pri_i(eoi_p), .eoi_sec_i(eoi_s), .pri_base_i(pri_base), .sec_base_i(sec_base),
    .int_o(int_o), .vec_o(vec_o), .vld_o(vld_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // monitor: pops expected vectors as the design presents them
  always @(negedge clk) begin
    if (rst_ni && vld_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected vld_o", 1, 0);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(vec_o == e[7:0], t, vec_o, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      chk(1'b0, "watchdog", cycles, 100000);
      summary();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_int(input string tag);
    for (int i = 0; i < 10; i++) begin
      if (int_o) return;
      @(negedge clk);
    end
    chk(1'b0, {tag, " int_o never rose"}, 0, 1);
  endtask

  task automatic ack_expect(input int v, input string tag);
    ack = 1'b1;
    exp_q.push_back(v);
    tag_q.push_back(tag);
    @(negedge clk);
    ack = 1'b0;
    chk(int_o == 1'b0, "R3 int_o low after ack", int_o, 0);
  endtask

  task automatic eoi_both();
    eoi_p = 1'b1; eoi_s = 1'b1;
    @(negedge clk);
    eoi_p = 1'b0; eoi_s = 1'b0;
  endtask

  task automatic eoi_pri();
    eoi_p = 1'b1;
    @(negedge clk);
    eoi_p = 1'b0;
  endtask

  task automatic serve(input int v, input string tag);
    wait_int(tag);
    ack_expect(v, tag);
    eoi_both();
  endtask

  initial begin
    step(1);
    chk({int_o, vld_o, vec_o} == '0, "R1 outputs in reset", {int_o, vld_o, vec_o}, 0);
    step(2);
    rst_ni = 1'b1;
    step(2);
    chk(int_o == 1'b0, "R1 int_o after reset", int_o, 0);
    chk(vld_o == 1'b0, "R1 vld_o after reset", vld_o, 0);

    // R2 / R3 primary line timing and vector
    irq[3] = 1'b1; step(1);
    chk(int_o == 1'b0, "R2 primary int one edge", int_o, 0);
    step(1);
    chk(int_o == 1'b1, "R2 primary int two edges", int_o, 1);
    ack_expect(8'h0B, "R3 primary vector line 3");
    eoi_both(); irq[3] = 1'b0; step(2);

    // R2 / R4 secondary line timing and vector
    irq[12] = 1'b1; step(2);
    chk(int_o == 1'b0, "R2 secondary int two edges", int_o, 0);
    step(1);
    chk(int_o == 1'b1, "R2 secondary int three edges", int_o, 1);
    ack_expect(8'h74, "R4 secondary vector line 12");
    eoi_both(); irq[12] = 1'b0; step(2);

    // R5 priority across and within cores
    irq[1] = 1'b1; irq[5] = 1'b1; irq[9] = 1'b1;
    serve(8'h09, "R5 line 1 first");
    serve(8'h71, "R5 secondary line 9 second");
    serve(8'h0D, "R5 line 5 last");
    irq[1] = 1'b0; irq[5] = 1'b0; irq[9] = 1'b0; step(2);
    irq[10] = 1'b1; irq[14] = 1'b1;
    serve(8'h72, "R5 secondary line 10 first");
    serve(8'h76, "R5 secondary line 14 next");
    irq[10] = 1'b0; irq[14] = 1'b0; step(2);

    // R6 pending request held; R10 re-evaluation after ack
    irq[5] = 1'b1; wait_int("R6 line 5");
    irq[0] = 1'b1; step(3);
    chk(int_o == 1'b1, "R6 int_o held", int_o, 1);
    ack_expect(8'h0D, "R6 first selection kept");
    step(1);
    chk(int_o == 1'b1, "R10 int_o one edge after ack", int_o, 1);
    ack_expect(8'h08, "R6 line 0 next");
    eoi_pri(); eoi_pri();
    irq[0] = 1'b0; irq[5] = 1'b0; step(2);

    // R7 in-service blocking and release
    irq[4] = 1'b1; wait_int("R7 line 4");
    ack_expect(8'h0C, "R7 line 4 vector");
    irq[6] = 1'b1; step(4);
    chk(int_o == 1'b0, "R7 line 6 blocked by 4", int_o, 0);
    irq[1] = 1'b1; wait_int("R7 line 1");
    ack_expect(8'h09, "R7 line 1 above in-service 4");
    eoi_pri(); step(3);
    chk(int_o == 1'b0, "R7 line 6 still blocked", int_o, 0);
    eoi_pri();
    serve(8'h0E, "R7 line 6 after release");
    irq[1] = 1'b0; irq[4] = 1'b0; irq[6] = 1'b0; step(2);

    // R8 masking
    mask[7] = 1'b1; irq[7] = 1'b1; step(4);
    chk(int_o == 1'b0, "R8 masked line silent", int_o, 0);
    mask[7] = 1'b0; step(1);
    chk(int_o == 1'b1, "R8 latched request after unmask", int_o, 1);
    serve(8'h0F, "R8 line 7 vector");
    irq[7] = 1'b0; step(2);
    mask[6] = 1'b1; irq[6] = 1'b1; step(2);
    irq[6] = 1'b0; step(2);
    mask[6] = 1'b0; step(3);
    chk(int_o == 1'b0, "R8 masked fall drops request", int_o, 0);
    irq[5] = 1'b1; wait_int("R8 line 5");
    irq[3] = 1'b1; step(2);
    irq[3] = 1'b0; step(2);
    ack_expect(8'h0D, "R8 line 5 vector");
    wait_int("R8 unmasked fall keeps request");
    ack_expect(8'h0B, "R8 line 3 kept");
    eoi_pri(); eoi_pri();
    irq[5] = 1'b0; step(2);

    // R9 stray acknowledge
    ack = 1'b1; step(1); ack = 1'b0;
    chk(vld_o == 1'b0, "R9 vld_o after stray ack", vld_o, 0);
    chk(int_o == 1'b0, "R9 int_o after stray ack", int_o, 0);
    step(2);

    // R3 / R4 low base bits ignored
    pri_base = 8'h2D; sec_base = 8'h97;
    irq[6] = 1'b1;
    serve(8'h2E, "R3 base low bits ignored");
    irq[15] = 1'b1;
    serve(8'h97, "R4 secondary base low bits ignored");
    irq[6] = 1'b0; irq[15] = 1'b0;
    step(3);
    chk(exp_q.size() == 0, "R3 all vectors seen", exp_q.size(), 0);
    summary();
  end
endmodule